// File: doc/BRIEF.md
# NAND Channel Command Dispatcher

This block sits on the controller side of one flash channel. Eight banks share that channel's I/O bus. Software writes an operation into a set of staging registers: the operation code, the column, the source and destination page addresses, and the DMA address, byte count and option bits. It then writes the target bank and an issue strobe. On the issue strobe the staged values are copied into a single wait slot. A status bit stays set until the slot is handed to a bank.

A command leaves the slot when two conditions hold. The shared bus must be free, and the ready/busy line of the target bank must be released. Banks share these lines in pairs: bank b and bank b+4 drive the same line. The command then holds the bus for a fixed transfer phase. After that the bank runs its cell operation for a modelled busy time, and the bus is free for other banks.

Software can follow a command through three stages of completion:
- **Issued:** the strobe was taken.
- **Accepted:** the status bit is clear again.
- **Finished:** the bank reads IDLE.

An issue strobe that arrives while the slot is still occupied is discarded, and a sticky overflow flag is raised.

Top module: `nand_chan_dispatch`

## Requirements
- R1: After reset, slot_full, overflow, bus_busy, every bank_busy bit and every rb_busy bit are 0.
- R2: Register addresses are: 0 operation, 1 bank, 2 column, 3 source page, 4 destination page, 5 DMA address, 6 DMA count, 7 options, 8 issue. An issue write while slot_full is 0 sets slot_full on the next cycle. slot_full stays set until the command is dispatched.
- R3: An issue write while slot_full is 1 is discarded: that command never reaches any bank. It also sets overflow, which then stays 1 until reset.
- R4: A held command is dispatched at the first clock edge after a cycle in which bus_busy is 0 and the ready/busy line of its bank is free. At that edge slot_full clears, and bus_busy is then 1 for exactly XFER_CYC cycles.
- R5: Only one transfer occupies the bus at a time. A bank turns busy only at the edge that starts a bus transfer addressed to it. Two back-to-back dispatches start XFER_CYC+1 cycles apart.
- R6: Bank b drives ready/busy line b mod 4, and rb_busy[r] is the OR of the busy flags of banks r and r+4. Two banks on one line are never busy together. A command for a bank whose line is held waits in the slot, and it starts busy one cycle after the line is released.
- R7: Operation codes are 0 read, 1 program, 2 erase and 3 copy-back. A bank stays busy for XFER_CYC cycles plus T_READ, T_PROG, T_ERASE or T_READ+T_PROG cycles respectively.
- R8: Banks on different ready/busy lines run their cell operations concurrently.
- R9: A page register holds the page in its low log2(PAGES_PER_BLK) bits and the block number above them. The row driven out is block*PAGES_PER_BLK+page, for both the source and the destination page.
- R10: Staging writes made after an issue do not alter the command held in the slot. The transfer carries the bank and rows that were staged at issue time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| slot_full | output | 1 | Wait slot occupied (status bit 0) |
| overflow | output | 1 | Sticky: issue strobe was discarded |
| bank_busy | output | NUM_BANKS | Per-bank state, 1 = BUSY, 0 = IDLE |
| rb_busy | output | NUM_BANKS/2 | Shared ready/busy lines, 1 = busy |
| bus_busy | output | 1 | Channel bus transfer in progress |
| xfer_bank | output | log2(NUM_BANKS) | Bank of the current or last transfer |
| xfer_op | output | 2 | Operation code of that transfer |
| xfer_col | output | COL_W | Column of that transfer |
| xfer_row | output | BLK_W+log2(PAGES_PER_BLK) | Source row |
| xfer_dst_row | output | BLK_W+log2(PAGES_PER_BLK) | Destination row (copy-back) |
| xfer_dma_addr | output | DMA_W | DMA address of that transfer |
| xfer_dma_cnt | output | CNT_W | DMA byte count of that transfer |
| xfer_opt | output | OPT_W | Option bits of that transfer |

## Verification
The following rules are checked by assertions on every cycle:
- No two banks sharing a ready/busy line are ever busy together.
- A bank turns busy only as a bus transfer to it begins.
- The bus is always occupied by the bank it names.
- The slot empties only into a bus transfer.
- The overflow flag sets and holds.

The directed scenarios cover what needs a whole command history:
- Exact busy lengths for each operation code.
- The one-cycle gap between back-to-back transfers.
- The exact release cycle of a paired bank.
- Row arithmetic.
- Staging writes made after issue leave the held command unchanged.
- A discarded command never reaches its bank.

// File: rtl/nchd_pkg.sv
package nchd_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_COPY  = 2'd3
  } op_e;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_OP    = 4'd0;
  localparam logic [ADDR_W-1:0] A_BANK  = 4'd1;
  localparam logic [ADDR_W-1:0] A_COL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ROW   = 4'd3;
  localparam logic [ADDR_W-1:0] A_DROW  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DADDR = 4'd5;
  localparam logic [ADDR_W-1:0] A_DCNT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_OPT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ISSUE = 4'd8;

endpackage

// File: rtl/nchd_stage.sv
// Staging registers plus the one-entry wait slot and the sticky overflow flag.
module nchd_stage
  import nchd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK_W = 3,
  parameter int COL_W  = 16,
  parameter int RAW_W  = 19,
  parameter int DMA_W  = 32,
  parameter int CNT_W  = 16,
  parameter int OPT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              slot_valid,
  output logic              overflow,
  output op_e               s_op,
  output logic [BANK_W-1:0] s_bank,
  output logic [COL_W-1:0]  s_col,
  output logic [RAW_W-1:0]  s_row,
  output logic [RAW_W-1:0]  s_drow,
  output logic [DMA_W-1:0]  s_daddr,
  output logic [CNT_W-1:0]  s_dcnt,
  output logic [OPT_W-1:0]  s_opt
);

  op_e               st_op;
  logic [BANK_W-1:0] st_bank;
  logic [COL_W-1:0]  st_col;
  logic [RAW_W-1:0]  st_row;
  logic [RAW_W-1:0]  st_drow;
  logic [DMA_W-1:0]  st_daddr;
  logic [CNT_W-1:0]  st_dcnt;
  logic [OPT_W-1:0]  st_opt;
  logic              issue_hit;

  assign issue_hit = we && (addr == A_ISSUE);

  // staging side
  always_ff @(posedge clk) begin
    if (rst) begin
      st_op    <= OP_READ;
      st_bank  <= '0;
      st_col   <= '0;
      st_row   <= '0;
      st_drow  <= '0;
      st_daddr <= '0;
      st_dcnt  <= '0;
      st_opt   <= '0;
    end else if (we) begin
      unique case (addr)
        A_OP:    st_op    <= op_e'(wdata[1:0]);
        A_BANK:  st_bank  <= wdata[BANK_W-1:0];
        A_COL:   st_col   <= wdata[COL_W-1:0];
        A_ROW:   st_row   <= wdata[RAW_W-1:0];
        A_DROW:  st_drow  <= wdata[RAW_W-1:0];
        A_DADDR: st_daddr <= wdata[DMA_W-1:0];
        A_DCNT:  st_dcnt  <= wdata[CNT_W-1:0];
        A_OPT:   st_opt   <= wdata[OPT_W-1:0];
        default: ;
      endcase
    end
  end

  // wait slot
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      overflow   <= 1'b0;
      s_op       <= OP_READ;
      s_bank     <= '0;
      s_col      <= '0;
      s_row      <= '0;
      s_drow     <= '0;
      s_daddr    <= '0;
      s_dcnt     <= '0;
      s_opt      <= '0;
    end else begin
      if (take) slot_valid <= 1'b0;
      if (issue_hit) begin
        if (slot_valid) begin
          overflow <= 1'b1;
        end else begin
          slot_valid <= 1'b1;
          s_op       <= st_op;
          s_bank     <= st_bank;
          s_col      <= st_col;
          s_row      <= st_row;
          s_drow     <= st_drow;
          s_daddr    <= st_daddr;
          s_dcnt     <= st_dcnt;
          s_opt      <= st_opt;
        end
      end
    end
  end

endmodule

// File: rtl/nchd_bank.sv
// One bank: counts down its modelled busy time (bus phase plus cell phase).
module nchd_bank #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] load,
  output logic          busy
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= load;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/nchd_disp.sv
// Channel bus arbiter: hands the slot to a bank when the bus and its R/B line are free.
module nchd_disp
  import nchd_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int NUM_RB        = 4,
  parameter int BANK_W        = 3,
  parameter int COL_W         = 16,
  parameter int BLK_W         = 12,
  parameter int PAGES_PER_BLK = 128,
  parameter int PAGE_W        = 7,
  parameter int DMA_W         = 32,
  parameter int CNT_W         = 16,
  parameter int OPT_W         = 8,
  parameter int XFER_CYC      = 24,
  parameter int T_READ        = 250,
  parameter int T_PROG        = 1300,
  parameter int T_ERASE       = 1500,
  parameter int TW            = 12,
  localparam int RAW_W = BLK_W + PAGE_W,
  localparam int RB_W  = (NUM_RB > 1) ? $clog2(NUM_RB) : 1,
  localparam int XW    = $clog2(XFER_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slot_valid,
  input  op_e                  s_op,
  input  logic [BANK_W-1:0]    s_bank,
  input  logic [COL_W-1:0]     s_col,
  input  logic [RAW_W-1:0]     s_row,
  input  logic [RAW_W-1:0]     s_drow,
  input  logic [DMA_W-1:0]     s_daddr,
  input  logic [CNT_W-1:0]     s_dcnt,
  input  logic [OPT_W-1:0]     s_opt,
  input  logic [NUM_RB-1:0]    rb_busy,
  output logic                 take,
  output logic [NUM_BANKS-1:0] start_vec,
  output logic [TW-1:0]        load_val,
  output logic                 bus_busy,
  output logic [BANK_W-1:0]    xfer_bank,
  output op_e                  xfer_op,
  output logic [COL_W-1:0]     xfer_col,
  output logic [RAW_W-1:0]     xfer_row,
  output logic [RAW_W-1:0]     xfer_dst_row,
  output logic [DMA_W-1:0]     xfer_dma_addr,
  output logic [CNT_W-1:0]     xfer_dma_cnt,
  output logic [OPT_W-1:0]     xfer_opt
);

  logic [XW-1:0]   bus_left;
  logic [RB_W-1:0] rb_idx;

  function automatic logic [TW-1:0] busy_len(input op_e op);
    case (op)
      OP_READ:  return TW'(XFER_CYC + T_READ);
      OP_PROG:  return TW'(XFER_CYC + T_PROG);
      OP_ERASE: return TW'(XFER_CYC + T_ERASE);
      OP_COPY:  return TW'(XFER_CYC + T_READ + T_PROG);
      default:  return TW'(XFER_CYC);
    endcase
  endfunction

  // block/page field pair -> linear row number
  function automatic logic [RAW_W-1:0] to_row(input logic [RAW_W-1:0] raw);
    logic [RAW_W-1:0] blk;
    logic [RAW_W-1:0] pg;
    blk = RAW_W'(raw[RAW_W-1:PAGE_W]);
    pg  = RAW_W'(raw[PAGE_W-1:0]);
    return blk * RAW_W'(PAGES_PER_BLK) + pg;
  endfunction

  assign rb_idx   = RB_W'(32'(s_bank) % NUM_RB);
  assign bus_busy = (bus_left != '0);
  assign take     = slot_valid && !bus_busy && !rb_busy[rb_idx];
  assign load_val = busy_len(s_op);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_start
    assign start_vec[b] = take && (s_bank == BANK_W'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_left      <= '0;
      xfer_bank     <= '0;
      xfer_op       <= OP_READ;
      xfer_col      <= '0;
      xfer_row      <= '0;
      xfer_dst_row  <= '0;
      xfer_dma_addr <= '0;
      xfer_dma_cnt  <= '0;
      xfer_opt      <= '0;
    end else if (take) begin
      bus_left      <= XW'(XFER_CYC);
      xfer_bank     <= s_bank;
      xfer_op       <= s_op;
      xfer_col      <= s_col;
      xfer_row      <= to_row(s_row);
      xfer_dst_row  <= to_row(s_drow);
      xfer_dma_addr <= s_daddr;
      xfer_dma_cnt  <= s_dcnt;
      xfer_opt      <= s_opt;
    end else if (bus_left != '0) begin
      bus_left <= bus_left - 1'b1;
    end
  end

endmodule

// File: rtl/nand_chan_dispatch.sv
module nand_chan_dispatch
  import nchd_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int DATA_W        = 32,
  parameter int COL_W         = 16,
  parameter int BLK_W         = 12,
  parameter int PAGES_PER_BLK = 128,
  parameter int DMA_W         = 32,
  parameter int CNT_W         = 16,
  parameter int OPT_W         = 8,
  parameter int XFER_CYC      = 24,
  parameter int T_READ        = 250,
  parameter int T_PROG        = 1300,
  parameter int T_ERASE       = 1500,
  localparam int NUM_RB = NUM_BANKS / 2,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLK),
  localparam int ROW_W  = BLK_W + PAGE_W,
  localparam int TW     = $clog2(XFER_CYC + T_READ + T_PROG + T_ERASE + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [3:0]           reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic                 slot_full,
  output logic                 overflow,
  output logic [NUM_BANKS-1:0] bank_busy,
  output logic [NUM_RB-1:0]    rb_busy,
  output logic                 bus_busy,
  output logic [BANK_W-1:0]    xfer_bank,
  output logic [1:0]           xfer_op,
  output logic [COL_W-1:0]     xfer_col,
  output logic [ROW_W-1:0]     xfer_row,
  output logic [ROW_W-1:0]     xfer_dst_row,
  output logic [DMA_W-1:0]     xfer_dma_addr,
  output logic [CNT_W-1:0]     xfer_dma_cnt,
  output logic [OPT_W-1:0]     xfer_opt
);

  op_e                  s_op;
  op_e                  x_op;
  logic [BANK_W-1:0]    s_bank;
  logic [COL_W-1:0]     s_col;
  logic [ROW_W-1:0]     s_row;
  logic [ROW_W-1:0]     s_drow;
  logic [DMA_W-1:0]     s_daddr;
  logic [CNT_W-1:0]     s_dcnt;
  logic [OPT_W-1:0]     s_opt;
  logic                 take;
  logic [NUM_BANKS-1:0] start_vec;
  logic [TW-1:0]        load_val;

  nchd_stage #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .COL_W(COL_W), .RAW_W(ROW_W),
    .DMA_W(DMA_W), .CNT_W(CNT_W), .OPT_W(OPT_W)
  ) u_stage (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .take(take), .slot_valid(slot_full), .overflow(overflow),
    .s_op(s_op), .s_bank(s_bank), .s_col(s_col), .s_row(s_row),
    .s_drow(s_drow), .s_daddr(s_daddr), .s_dcnt(s_dcnt), .s_opt(s_opt)
  );

  nchd_disp #(
    .NUM_BANKS(NUM_BANKS), .NUM_RB(NUM_RB), .BANK_W(BANK_W), .COL_W(COL_W),
    .BLK_W(BLK_W), .PAGES_PER_BLK(PAGES_PER_BLK), .PAGE_W(PAGE_W),
    .DMA_W(DMA_W), .CNT_W(CNT_W), .OPT_W(OPT_W), .XFER_CYC(XFER_CYC),
    .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .TW(TW)
  ) u_disp (
    .clk(clk), .rst(rst), .slot_valid(slot_full), .s_op(s_op),
    .s_bank(s_bank), .s_col(s_col), .s_row(s_row), .s_drow(s_drow),
    .s_daddr(s_daddr), .s_dcnt(s_dcnt), .s_opt(s_opt), .rb_busy(rb_busy),
    .take(take), .start_vec(start_vec), .load_val(load_val),
    .bus_busy(bus_busy), .xfer_bank(xfer_bank), .xfer_op(x_op),
    .xfer_col(xfer_col), .xfer_row(xfer_row), .xfer_dst_row(xfer_dst_row),
    .xfer_dma_addr(xfer_dma_addr), .xfer_dma_cnt(xfer_dma_cnt),
    .xfer_opt(xfer_opt)
  );

  assign xfer_op = x_op;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    nchd_bank #(.TW(TW)) u_bank (
      .clk(clk), .rst(rst), .start(start_vec[b]), .load(load_val),
      .busy(bank_busy[b])
    );
  end

  // paired banks drive one shared ready/busy line
  for (genvar r = 0; r < NUM_RB; r++) begin : g_rb
    assign rb_busy[r] = bank_busy[r] | bank_busy[r + NUM_RB];
  end

endmodule

// File: rtl/nchd_chk.sv
module nchd_chk
  import nchd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int NUM_RB    = 4,
  parameter int BANK_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_we,
  input logic [3:0]           reg_addr,
  input logic                 slot_full,
  input logic                 overflow,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic                 bus_busy,
  input logic [BANK_W-1:0]    xfer_bank
);

  // R2
  slot_set_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_ISSUE && !slot_full) |=> slot_full);

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_ISSUE && slot_full) |=> overflow);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R4
  take_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(slot_full) |-> bus_busy);

  // R5
  bus_owner_chk: assert property (@(posedge clk) disable iff (rst)
    bus_busy |-> bank_busy[xfer_bank]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    // R5
    bank_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bank_busy[b]) |-> (bus_busy && xfer_bank == BANK_W'(b)));
  end

  for (genvar r = 0; r < NUM_RB; r++) begin : g_r
    // R6
    pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(bank_busy[r] && bank_busy[r + NUM_RB]));
  end

endmodule

bind nand_chan_dispatch nchd_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_RB(NUM_RB), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .slot_full(slot_full), .overflow(overflow), .bank_busy(bank_busy),
  .bus_busy(bus_busy), .xfer_bank(xfer_bank)
);

// File: tb/nand_chan_dispatch_tb.sv
module nand_chan_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XFER  = 24;
  localparam int TRD   = 40;
  localparam int TPG   = 130;
  localparam int TER   = 150;
  localparam int PPB   = 128;
  localparam int WDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        slot_full, overflow, bus_busy;
  logic [7:0]  bank_busy;
  logic [3:0]  rb_busy;
  logic [2:0]  xfer_bank;
  logic [1:0]  xfer_op;
  logic [15:0] xfer_col;
  logic [18:0] xfer_row, xfer_dst_row;
  logic [31:0] xfer_dma_addr;
  logic [15:0] xfer_dma_cnt;
  logic [7:0]  xfer_opt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_chan_dispatch #(
    .XFER_CYC(XFER), .T_READ(TRD), .T_PROG(TPG), .T_ERASE(TER)
  ) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .slot_full(slot_full), .overflow(overflow),
    .bank_busy(bank_busy), .rb_busy(rb_busy), .bus_busy(bus_busy),
    .xfer_bank(xfer_bank), .xfer_op(xfer_op), .xfer_col(xfer_col),
    .xfer_row(xfer_row), .xfer_dst_row(xfer_dst_row),
    .xfer_dma_addr(xfer_dma_addr), .xfer_dma_cnt(xfer_dma_cnt),
    .xfer_opt(xfer_opt)
  );

  // bank activity monitor, sampled at falling edges
  logic       seen_clr = 1'b0;
  logic [7:0] seen = '0;
  logic [7:0] prev = '0;
  int         cyc = 0;
  int         rise_at [8];
  int         fall_at [8];

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    prev <= bank_busy;
    if (seen_clr) seen <= '0;
    else          seen <= seen | bank_busy;
    for (int b = 0; b < 8; b++) begin
      if (bank_busy[b] && !prev[b]) rise_at[b] <= cyc;
      if (!bank_busy[b] && prev[b]) fall_at[b] <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic issue(input int op, input int bank, input int col,
                       input int blk, input int pg, input int dblk, input int dpg);
    wr(4'd0, 32'(op));
    wr(4'd2, 32'(col));
    wr(4'd3, 32'(blk * PPB + pg));
    wr(4'd4, 32'(dblk * PPB + dpg));
    wr(4'd5, 32'h1000 + 32'(bank));
    wr(4'd6, 32'd512);
    wr(4'd7, 32'h3);
    wr(4'd1, 32'(bank));
    wr(4'd8, 32'd0);
  endtask

  task automatic busy_len(input int b, output int len);
    while (!bank_busy[b]) @(negedge clk);
    len = 0;
    while (bank_busy[b]) begin len++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    while (bank_busy != '0 || slot_full) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(slot_full == 1'b0, "R1 slot_full", slot_full, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    chk(bank_busy == '0, "R1 bank_busy", bank_busy, 0);
    chk(rb_busy == '0, "R1 rb_busy", rb_busy, 0);
    chk(bus_busy == 1'b0, "R1 bus_busy", bus_busy, 0);
  endtask

  task automatic t_read();
    int len;
    issue(0, 2, 16'h40, 3, 5, 0, 0);
    chk(slot_full == 1'b1, "R2 slot set after issue", slot_full, 1);
    busy_len(2, len);
    chk(len == XFER + TRD, "R7 read busy length", len, XFER + TRD);
    chk(slot_full == 1'b0, "R4 slot cleared on dispatch", slot_full, 0);
    chk(xfer_bank == 3'd2, "R9 transfer bank", xfer_bank, 2);
    chk(xfer_op == 2'd0, "R9 transfer op", xfer_op, 0);
    chk(xfer_col == 16'h40, "R9 transfer column", xfer_col, 16'h40);
    chk(xfer_row == 19'(3 * PPB + 5), "R9 row arithmetic", xfer_row, 3 * PPB + 5);
    wait_idle();
  endtask

  task automatic t_ops();
    int len;
    issue(1, 0, 0, 1, 1, 0, 0);
    busy_len(0, len);
    chk(len == XFER + TPG, "R7 program busy length", len, XFER + TPG);
    issue(2, 1, 0, 4, 0, 0, 0);
    busy_len(1, len);
    chk(len == XFER + TER, "R7 erase busy length", len, XFER + TER);
    issue(3, 3, 0, 7, 127, 9, 1);
    busy_len(3, len);
    chk(len == XFER + TRD + TPG, "R7 copy-back busy length", len, XFER + TRD + TPG);
    chk(xfer_row == 19'(7 * PPB + 127), "R9 copy source row", xfer_row, 7 * PPB + 127);
    chk(xfer_dst_row == 19'(9 * PPB + 1), "R9 copy destination row", xfer_dst_row, 9 * PPB + 1);
    wait_idle();
  endtask

  task automatic t_parallel();
    issue(0, 0, 0, 2, 2, 0, 0);
    issue(0, 1, 0, 2, 3, 0, 0);
    while (!bank_busy[1]) @(negedge clk);
    chk(bank_busy[0] == 1'b1, "R8 concurrent cell ops", bank_busy[0], 1);
    chk(rb_busy == 4'b0011, "R6 rb lines for banks 0 and 1", rb_busy, 4'b0011);
    @(negedge clk);
    chk(rise_at[1] - rise_at[0] == XFER + 1, "R5 back-to-back spacing",
        rise_at[1] - rise_at[0], XFER + 1);
    wait_idle();
  endtask

  task automatic t_pair();
    seen_clr = 1'b1; @(negedge clk); seen_clr = 1'b0;
    issue(1, 1, 0, 5, 5, 0, 0);
    issue(0, 5, 0, 2, 3, 0, 0);
    wr(4'd1, 32'd6);
    wr(4'd3, 32'(9 * PPB));
    chk(slot_full == 1'b1, "R6 partner command held", slot_full, 1);
    wait_idle();
    chk(rise_at[5] == fall_at[1] + 1, "R6 start after line release",
        rise_at[5], fall_at[1] + 1);
    chk(xfer_bank == 3'd5, "R10 held bank unchanged", xfer_bank, 5);
    chk(xfer_row == 19'(2 * PPB + 3), "R10 held row unchanged", xfer_row, 2 * PPB + 3);
    chk(seen[6] == 1'b0, "R10 restaged bank untouched", seen[6], 0);
  endtask

  task automatic t_overflow();
    seen_clr = 1'b1; @(negedge clk); seen_clr = 1'b0;
    issue(1, 3, 0, 1, 0, 0, 0);
    issue(0, 7, 0, 1, 1, 0, 0);
    chk(overflow == 1'b0, "R3 no overflow yet", overflow, 0);
    issue(2, 6, 0, 8, 0, 0, 0);
    chk(overflow == 1'b1, "R3 overflow on full slot", overflow, 1);
    wait_idle();
    chk(seen[6] == 1'b0, "R3 discarded command never ran", seen[6], 0);
    chk(seen[7] == 1'b1, "R3 held command ran", seen[7], 1);
    chk(overflow == 1'b1, "R3 overflow sticky", overflow, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(overflow == 1'b0, "R1 overflow cleared by reset", overflow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read();
    t_ops();
    t_parallel();
    t_pair();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule